// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Status Flags and Split Interrupts

This block receives characters from an asynchronous serial line. The line is sampled on an enable that pulses at sixteen times the bit rate. A frame is a low start bit, then 8 or 9 data bits with the least significant bit first, then an optional parity bit, then a high stop bit. A state machine walks through each frame. Each bit is sampled three times near its centre and decided by majority vote. The completed character is moved into a receive data register.

Six status flags record what happened on the line:

- receive-full
- idle line
- overrun
- noise
- framing error
- parity error

Each flag has its own enable. Enabled receive-full and idle raise a receive interrupt request. Enabled overrun, noise, framing and parity raise a separate error interrupt request. Software clears the flags with a two-step sequence: it reads the status, then it reads the data.

The state machine has five states:

- `ST_HUNT`: waiting for a start edge.
- `ST_START`: checking the start bit.
- `ST_DATA`: shifting in data bits.
- `ST_PARITY`: checking the parity bit.
- `ST_STOP`: checking the stop bit and completing the character.

Its transitions are:

- `ST_HUNT`→`ST_START`: a low level is seen on a sample tick.
- `ST_START`→`ST_HUNT`: false start, the centre majority is high.
- `ST_START`→`ST_DATA`: valid start bit.
- `ST_DATA`→`ST_DATA`: more data bits remain.
- `ST_DATA`→`ST_PARITY`: the last data bit arrives with parity on.
- `ST_DATA`→`ST_STOP`: the last data bit arrives with parity off.
- `ST_PARITY`→`ST_STOP`: after the parity bit.
- `ST_STOP`→`ST_HUNT`: at the centre of the stop bit, where the character completes.

Top module: `serial_rx_flags`

## Requirements
- R1: After reset, all six flags are 0, both interrupt requests are 0 and `rx_data` is 0.
- R2: In 8-bit mode (`cfg_nine`=0), data arrives LSB first into `rx_data[7:0]` and `rx_data[8]` reads 0. In 9-bit mode (`cfg_nine`=1), all 9 bits are stored.
- R3: When a character completes and the data register is empty, the character is stored and `st_full` sets. `irq_rx` is high when `st_full` and `ie_full` are both set.
- R4: When a character completes while `st_full` is set, `st_ovr` sets, the old character stays in `rx_data` and the new one is discarded. `irq_err` follows `st_ovr` when `ie_ovr` is set.
- R5: Each bit is sampled at oversampling ticks 7, 8 and 9 of its bit time, counted from the detected start edge. The majority of the three samples is the bit value. If the three samples disagree on any bit of the frame (start, data, parity or stop), `st_noise` sets when the character completes.
- R6: If the stop bit's majority value is 0, `st_frame` sets. This includes an all-zero break character.
- R7: With `cfg_par_en`=1, a parity bit follows the data bits. `st_par` sets when the parity is wrong: even parity (`cfg_par_odd`=0) needs an even count of 1s over data and parity, and odd parity needs an odd count. With `cfg_par_en`=0 there is no parity bit and `st_par` never sets.
- R8: `irq_err` is high exactly when one of overrun, noise, framing or parity is set together with its own enable. A set flag whose enable is clear has no effect on `irq_err`.
- R9: The idle flag sets after a completed character followed by an unbroken high line. The required length is 10 bit times (160 ticks) in 8-bit mode and 11 bit times (176 ticks) in 9-bit mode. It sets at most once per idle period and never before the first character after reset. `irq_rx` follows it when `ie_idle` is set.
- R10: A `rd_data` pulse clears exactly the flags that were set at the most recent `rd_status` pulse before it. A flag that was set after that status read is kept. A `rd_data` pulse with no status read before it clears nothing.
- R11: A start bit whose centre majority is 1 is rejected as a false start. The state machine returns to hunting and no character or flag results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial receive line, idle high |
| samp_tick | input | 1 | Sampling enable at 16x the bit rate |
| cfg_nine | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | 1 adds a parity bit to each frame |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| ie_full | input | 1 | Enable receive-full onto `irq_rx` |
| ie_idle | input | 1 | Enable idle onto `irq_rx` |
| ie_ovr | input | 1 | Enable overrun onto `irq_err` |
| ie_noise | input | 1 | Enable noise onto `irq_err` |
| ie_frame | input | 1 | Enable framing error onto `irq_err` |
| ie_par | input | 1 | Enable parity error onto `irq_err` |
| rd_status | input | 1 | One-cycle strobe: status has been read |
| rd_data | input | 1 | One-cycle strobe: data has been read |
| rx_data | output | 9 | Receive data register |
| st_full | output | 1 | Receive-full flag |
| st_idle | output | 1 | Idle-line flag |
| st_ovr | output | 1 | Overrun flag |
| st_noise | output | 1 | Noise flag |
| st_frame | output | 1 | Framing error flag |
| st_par | output | 1 | Parity error flag |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
The bench uses the default parameters: sixteen ticks per bit, a 9-bit data register and a two-stage input synchronizer. It holds `samp_tick` high, so one bit lasts sixteen clocks. Each oversampling tick then matches a known clock inside a bit. This lets a one-clock glitch be placed on exactly the tick-8 sample, which gives noise while the majority value stays correct. It also puts the 160-tick and 176-tick idle windows only a few hundred clocks apart, so the bench can check both sides of each threshold.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_t;

    // flag positions inside the status vector
    localparam int NFLAGS   = 6;
    localparam int FL_FULL  = 0;
    localparam int FL_IDLE  = 1;
    localparam int FL_OVR   = 2;
    localparam int FL_NOISE = 3;
    localparam int FL_FRAME = 4;
    localparam int FL_PAR   = 5;

    // which flags feed which interrupt request
    localparam logic [NFLAGS-1:0] RX_GROUP  = 6'b000011;
    localparam logic [NFLAGS-1:0] ERR_GROUP = 6'b111100;

endpackage

// File: rtl/srx_bit_sampler.sv
module srx_bit_sampler #(
    parameter int OVS   = 16,
    parameter int SYNC  = 2,
    localparam int PH_W = $clog2(OVS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_in,
    input  logic            tick,
    input  logic [PH_W-1:0] phase,
    output logic            rx_s,
    output logic            bit_ready,
    output logic            bit_val,
    output logic            bit_noise
);
    localparam int MID = OVS / 2;
    localparam logic [PH_W-1:0] PH_A = PH_W'(MID - 1);
    localparam logic [PH_W-1:0] PH_B = PH_W'(MID);
    localparam logic [PH_W-1:0] PH_C = PH_W'(MID + 1);

    logic [SYNC-1:0] sync_q;
    logic            samp_a, samp_b;

    // synchronizer, reset to the idle (high) level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], rx_in};
        end
    end

    assign rx_s = sync_q[SYNC-1];

    // first two of the three centre samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_a <= 1'b1;
            samp_b <= 1'b1;
        end else if (tick) begin
            if (phase == PH_A) samp_a <= rx_s;
            if (phase == PH_B) samp_b <= rx_s;
        end
    end

    // third sample is the live value; decide on that tick
    always_comb begin
        bit_ready = tick && (phase == PH_C);
        bit_val   = (samp_a & samp_b) | (samp_a & rx_s) | (samp_b & rx_s);
        bit_noise = !((samp_a == samp_b) && (samp_b == rx_s));
    end

endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
    import serial_rx_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DW     = 9,
    localparam int PH_W  = $clog2(OVS),
    localparam int IDX_W = $clog2(DW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            rx_s,
    input  logic            bit_ready,
    input  logic            bit_val,
    input  logic            bit_noise,
    input  logic            cfg_nine,
    input  logic            cfg_par_en,
    input  logic            cfg_par_odd,
    output logic [PH_W-1:0] phase,
    output logic            hunting,
    output logic            done,
    output logic [DW-1:0]   done_data,
    output logic            done_noise,
    output logic            done_frame,
    output logic            done_par
);
    rx_state_t        st, nxt;
    logic [IDX_W-1:0] bit_idx;
    logic [IDX_W-1:0] last_idx;
    logic [DW-1:0]    shreg;
    logic             noise_acc;
    logic             par_acc;
    logic             par_bad;

    assign last_idx = cfg_nine ? IDX_W'(DW - 1) : IDX_W'(DW - 2);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_HUNT;
        end else begin
            st <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            ST_HUNT:   if (tick && !rx_s) nxt = ST_START;
            ST_START:  if (bit_ready) nxt = bit_val ? ST_HUNT : ST_DATA;
            ST_DATA:   if (bit_ready && (bit_idx == last_idx))
                           nxt = cfg_par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_ready) nxt = ST_STOP;
            ST_STOP:   if (bit_ready) nxt = ST_HUNT;
            default:   nxt = ST_HUNT;
        endcase
    end

    // bit timing and character assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase     <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            noise_acc <= 1'b0;
            par_acc   <= 1'b0;
            par_bad   <= 1'b0;
        end else if (st == ST_HUNT) begin
            phase <= '0;
            if (tick && !rx_s) begin
                phase     <= PH_W'(1);
                bit_idx   <= '0;
                shreg     <= '0;
                noise_acc <= 1'b0;
                par_acc   <= 1'b0;
                par_bad   <= 1'b0;
            end
        end else if (tick) begin
            phase <= phase + 1'b1;
            if (bit_ready) begin
                noise_acc <= noise_acc | bit_noise;
                if (st == ST_DATA) begin
                    shreg   <= {bit_val, shreg[DW-1:1]};
                    par_acc <= par_acc ^ bit_val;
                    bit_idx <= bit_idx + 1'b1;
                end
                if (st == ST_PARITY) begin
                    par_bad <= par_acc ^ bit_val ^ cfg_par_odd;
                end
            end
        end
    end

    // outputs
    always_comb begin
        hunting    = (st == ST_HUNT);
        done       = (st == ST_STOP) && bit_ready;
        done_data  = cfg_nine ? shreg : (shreg >> 1);
        done_noise = noise_acc | bit_noise;
        done_frame = !bit_val;
        done_par   = cfg_par_en && par_bad;
    end

endmodule

// File: rtl/srx_idle_det.sv
module srx_idle_det #(
    parameter int OVS   = 16,
    parameter int DW    = 9,
    localparam int LONG_T  = OVS * (DW + 2),
    localparam int SHORT_T = OVS * (DW + 1),
    localparam int CW      = $clog2(LONG_T + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hunting,
    input  logic rx_s,
    input  logic cfg_nine,
    input  logic frame_done,
    output logic idle_set
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] thr;
    logic          armed;
    logic          count_en;

    assign thr      = cfg_nine ? CW'(LONG_T) : CW'(SHORT_T);
    assign count_en = tick && hunting && rx_s;
    assign idle_set = armed && count_en && (cnt == thr - 1'b1);

    // consecutive high ticks while waiting for a start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!hunting || (tick && !rx_s)) begin
            cnt <= '0;
        end else if (count_en && (cnt != thr)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // one idle report per completed character
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (frame_done) begin
            armed <= 1'b1;
        end else if (idle_set) begin
            armed <= 1'b0;
        end
    end

endmodule

// File: rtl/srx_status.sv
module srx_status
    import serial_rx_pkg::*;
#(
    parameter int DW = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DW-1:0]     done_data,
    input  logic              done_noise,
    input  logic              done_frame,
    input  logic              done_par,
    input  logic              idle_set,
    input  logic              rd_status,
    input  logic              rd_data,
    input  logic [NFLAGS-1:0] ie,
    output logic [NFLAGS-1:0] flags,
    output logic [DW-1:0]     rx_data,
    output logic              irq_rx,
    output logic              irq_err
);
    logic [NFLAGS-1:0] set_v;
    logic [NFLAGS-1:0] clr_v;
    logic [NFLAGS-1:0] snap;
    logic [NFLAGS-1:0] masked;

    always_comb begin
        set_v           = '0;
        set_v[FL_FULL]  = done && !flags[FL_FULL];
        set_v[FL_IDLE]  = idle_set;
        set_v[FL_OVR]   = done && flags[FL_FULL];
        set_v[FL_NOISE] = done && done_noise;
        set_v[FL_FRAME] = done && done_frame;
        set_v[FL_PAR]   = done && done_par;
        clr_v           = rd_data ? snap : '0;
    end

    // flags seen at the status read, armed for the data read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap <= '0;
        end else if (rd_data) begin
            snap <= '0;
        end else if (rd_status) begin
            snap <= flags;
        end
    end

    generate
        for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flags[i] <= 1'b0;
                end else if (set_v[i]) begin
                    flags[i] <= 1'b1;
                end else if (clr_v[i]) begin
                    flags[i] <= 1'b0;
                end
            end
        end
    endgenerate

    // data register loads only when empty
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
        end else if (set_v[FL_FULL]) begin
            rx_data <= done_data;
        end
    end

    always_comb begin
        masked  = flags & ie;
        irq_rx  = |(masked & RX_GROUP);
        irq_err = |(masked & ERR_GROUP);
    end

endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags
    import serial_rx_pkg::*;
#(
    parameter int OVS  = 16,
    parameter int DW   = 9,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_in,
    input  logic          samp_tick,
    input  logic          cfg_nine,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          ie_full,
    input  logic          ie_idle,
    input  logic          ie_ovr,
    input  logic          ie_noise,
    input  logic          ie_frame,
    input  logic          ie_par,
    input  logic          rd_status,
    input  logic          rd_data,
    output logic [DW-1:0] rx_data,
    output logic          st_full,
    output logic          st_idle,
    output logic          st_ovr,
    output logic          st_noise,
    output logic          st_frame,
    output logic          st_par,
    output logic          irq_rx,
    output logic          irq_err
);
    localparam int PH_W = $clog2(OVS);

    logic [PH_W-1:0]   phase;
    logic              rx_s, bit_ready, bit_val, bit_noise;
    logic              hunting, done, done_noise, done_frame, done_par;
    logic [DW-1:0]     done_data;
    logic              idle_set;
    logic [NFLAGS-1:0] ie, flags;

    always_comb begin
        ie           = '0;
        ie[FL_FULL]  = ie_full;
        ie[FL_IDLE]  = ie_idle;
        ie[FL_OVR]   = ie_ovr;
        ie[FL_NOISE] = ie_noise;
        ie[FL_FRAME] = ie_frame;
        ie[FL_PAR]   = ie_par;
    end

    srx_bit_sampler #(.OVS(OVS), .SYNC(SYNC)) u_samp (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick(samp_tick),
        .phase(phase), .rx_s(rx_s), .bit_ready(bit_ready),
        .bit_val(bit_val), .bit_noise(bit_noise)
    );

    srx_frame_fsm #(.OVS(OVS), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(samp_tick), .rx_s(rx_s),
        .bit_ready(bit_ready), .bit_val(bit_val), .bit_noise(bit_noise),
        .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .phase(phase), .hunting(hunting), .done(done), .done_data(done_data),
        .done_noise(done_noise), .done_frame(done_frame), .done_par(done_par)
    );

    srx_idle_det #(.OVS(OVS), .DW(DW)) u_idle (
        .clk(clk), .rst_n(rst_n), .tick(samp_tick), .hunting(hunting),
        .rx_s(rx_s), .cfg_nine(cfg_nine), .frame_done(done), .idle_set(idle_set)
    );

    srx_status #(.DW(DW)) u_stat (
        .clk(clk), .rst_n(rst_n), .done(done), .done_data(done_data),
        .done_noise(done_noise), .done_frame(done_frame), .done_par(done_par),
        .idle_set(idle_set), .rd_status(rd_status), .rd_data(rd_data),
        .ie(ie), .flags(flags), .rx_data(rx_data),
        .irq_rx(irq_rx), .irq_err(irq_err)
    );

    assign st_full  = flags[FL_FULL];
    assign st_idle  = flags[FL_IDLE];
    assign st_ovr   = flags[FL_OVR];
    assign st_noise = flags[FL_NOISE];
    assign st_frame = flags[FL_FRAME];
    assign st_par   = flags[FL_PAR];

endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int DW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_par_en,
    input logic          rd_data,
    input logic [DW-1:0] rx_data,
    input logic          st_full,
    input logic          st_idle,
    input logic          st_ovr,
    input logic          st_noise,
    input logic          st_frame,
    input logic          st_par,
    input logic          irq_rx,
    input logic          irq_err
);
    // old character is held while the register is full and unread
    p_keep_old_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_full && !rd_data) |=> $stable(rx_data));

    // an overrun needs a character already waiting
    p_ovr_needs_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_ovr) |-> $past(st_full));

    // full and idle flags drop only on a data read
    p_full_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_full) |-> $past(rd_data));
    p_idle_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_idle) |-> $past(rd_data));

    // parity errors only with parity enabled
    p_par_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_par) |-> $past(cfg_par_en));

    // requests only with a source flag present
    p_err_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> (st_ovr || st_noise || st_frame || st_par));
    p_rx_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> (st_full || st_idle));

endmodule

bind serial_rx_flags srx_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_par_en(cfg_par_en), .rd_data(rd_data),
    .rx_data(rx_data), .st_full(st_full), .st_idle(st_idle), .st_ovr(st_ovr),
    .st_noise(st_noise), .st_frame(st_frame), .st_par(st_par),
    .irq_rx(irq_rx), .irq_err(irq_err)
);

// File: tb/serial_rx_flags_tb_top.sv
`timescale 1ns/1ps
module serial_rx_flags_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_in = 1'b1;
    logic       samp_tick = 1'b1;
    logic       cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic       ie_full = 1'b0, ie_idle = 1'b0, ie_ovr = 1'b0;
    logic       ie_noise = 1'b0, ie_frame = 1'b0, ie_par = 1'b0;
    logic       rd_status = 1'b0, rd_data = 1'b0;
    logic [8:0] rx_data;
    logic       st_full, st_idle, st_ovr, st_noise, st_frame, st_par;
    logic       irq_rx, irq_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    serial_rx_flags dut_i (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .samp_tick(samp_tick),
        .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .ie_full(ie_full), .ie_idle(ie_idle), .ie_ovr(ie_ovr),
        .ie_noise(ie_noise), .ie_frame(ie_frame), .ie_par(ie_par),
        .rd_status(rd_status), .rd_data(rd_data), .rx_data(rx_data),
        .st_full(st_full), .st_idle(st_idle), .st_ovr(st_ovr),
        .st_noise(st_noise), .st_frame(st_frame), .st_par(st_par),
        .irq_rx(irq_rx), .irq_err(irq_err)
    );

    // stimulus: data, nine, parity on, odd, stop level, parity flip,
    // glitch bit position (31 = none); expected data, noise, frame, parity
    typedef struct packed {
        logic [8:0] d;
        logic       nine, pen, podd, stopv, pflip;
        logic [4:0] gpos;
        logic [8:0] exp_d;
        logic       exp_noise, exp_frame, exp_par;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{9'h0A5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd31, 9'h0A5, 1'b0, 1'b0, 1'b0},
        '{9'h1C3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 5'd31, 9'h1C3, 1'b0, 1'b0, 1'b0},
        '{9'h03C, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 5'd31, 9'h03C, 1'b0, 1'b0, 1'b0},
        '{9'h03D, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 5'd31, 9'h03D, 1'b0, 1'b0, 1'b0},
        '{9'h055, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 5'd31, 9'h055, 1'b0, 1'b0, 1'b1},
        '{9'h00F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd31, 9'h00F, 1'b0, 1'b1, 1'b0},
        '{9'h081, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd4,  9'h081, 1'b1, 1'b0, 1'b0},
        '{9'h100, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 5'd11, 9'h100, 1'b1, 1'b0, 1'b0},
        '{9'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd31, 9'h000, 1'b0, 1'b1, 1'b0},
        '{9'h0FF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0,  9'h0FF, 1'b1, 1'b0, 1'b0},
        '{9'h0AA, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 5'd31, 9'h0AA, 1'b0, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one bit lasts 16 clocks; the glitch flips only clock 8 of its bit
    task automatic send_frame(input logic [8:0] d, input logic nine, input logic pen,
                              input logic podd, input logic stopv, input logic pflip,
                              input int gpos);
        int   nb;
        int   total;
        logic v;
        logic p;
        nb    = nine ? 9 : 8;
        total = 1 + nb + (pen ? 1 : 0) + 1;
        p     = podd ^ pflip;
        for (int i = 0; i < nb; i++) p = p ^ d[i];
        for (int b = 0; b < total; b++) begin
            if (b == 0)                 v = 1'b0;
            else if (b <= nb)           v = d[b-1];
            else if (pen && b == nb+1)  v = p;
            else                        v = stopv;
            for (int c = 0; c < 16; c++) begin
                @(negedge clk);
                rx_in = (b == gpos && c == 8) ? ~v : v;
            end
        end
        @(negedge clk);
        rx_in = 1'b1;
    endtask

    task automatic pulse_status();
        @(negedge clk); rd_status = 1'b1;
        @(negedge clk); rd_status = 1'b0;
    endtask

    task automatic pulse_data();
        @(negedge clk); rd_data = 1'b1;
        @(negedge clk); rd_data = 1'b0;
    endtask

    task automatic clear_all();
        pulse_status();
        pulse_data();
        wait_clks(2);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; rx_in = 1'b1;
        wait_clks(3);
        rst_n = 1'b1;
        wait_clks(3);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", 150000);
        finish_run();
    end

    initial begin
        wait_clks(4);
        rst_n = 1'b1;
        wait_clks(2);
        // R1 reset state
        chk("R1 flags after reset", {10'd0, st_par, st_frame, st_noise, st_ovr, st_idle, st_full}, 16'h0);
        chk("R1 irqs after reset", {14'd0, irq_rx, irq_err}, 16'h0);
        chk("R1 data after reset", {7'd0, rx_data}, 16'h0);

        // table-driven frames: R2 R3 R5 R6 R7 R8
        ie_full = 1; ie_ovr = 1; ie_noise = 1; ie_frame = 1; ie_par = 1;
        for (int k = 0; k < NV; k++) begin
            cfg_nine = VECS[k].nine; cfg_par_en = VECS[k].pen; cfg_par_odd = VECS[k].podd;
            wait_clks(4);
            send_frame(VECS[k].d, VECS[k].nine, VECS[k].pen, VECS[k].podd,
                       VECS[k].stopv, VECS[k].pflip, int'(VECS[k].gpos));
            wait_clks(24);
            chk($sformatf("R2 vec%0d data", k), {7'd0, rx_data}, {7'd0, VECS[k].exp_d});
            chk($sformatf("R3 vec%0d full+irq_rx", k), {14'd0, st_full, irq_rx}, 16'h3);
            chk($sformatf("R5 vec%0d noise", k), {15'd0, st_noise}, {15'd0, VECS[k].exp_noise});
            chk($sformatf("R6 vec%0d frame", k), {15'd0, st_frame}, {15'd0, VECS[k].exp_frame});
            chk($sformatf("R7 vec%0d parity", k), {15'd0, st_par}, {15'd0, VECS[k].exp_par});
            chk($sformatf("R8 vec%0d irq_err", k), {15'd0, irq_err},
                {15'd0, VECS[k].exp_noise | VECS[k].exp_frame | VECS[k].exp_par});
            clear_all();
            chk($sformatf("R10 vec%0d cleared", k),
                {10'd0, st_par, st_frame, st_noise, st_ovr, st_idle, st_full}, 16'h0);
        end

        // R3 enable gating of receive request
        do_reset();
        cfg_nine = 0; cfg_par_en = 0; ie_full = 0;
        send_frame(9'h012, 0, 0, 0, 1, 0, 31);
        wait_clks(24);
        chk("R3 full without enable no irq", {14'd0, st_full, irq_rx}, 16'h2);
        ie_full = 1;
        wait_clks(1);
        chk("R3 irq_rx with enable", {15'd0, irq_rx}, 16'h1);

        // R10 data read alone clears nothing
        pulse_data();
        wait_clks(2);
        chk("R10 data read alone keeps full", {15'd0, st_full}, 16'h1);

        // R4 overrun keeps the old character
        send_frame(9'h0E7, 0, 0, 0, 1, 0, 31);
        wait_clks(24);
        chk("R4 old data kept", {7'd0, rx_data}, 16'h012);
        chk("R4 overrun flag + irq_err", {14'd0, st_ovr, irq_err}, 16'h3);
        ie_ovr = 0; ie_noise = 1; ie_frame = 1; ie_par = 1;
        wait_clks(1);
        chk("R8 overrun disabled no irq_err", {15'd0, irq_err}, 16'h0);
        clear_all();

        // R10 flag set after status read survives the data read
        ie_ovr = 1;
        send_frame(9'h033, 0, 0, 0, 1, 0, 31);
        wait_clks(24);
        pulse_status();
        send_frame(9'h044, 0, 0, 0, 1, 0, 31);
        wait_clks(24);
        pulse_data();
        wait_clks(2);
        chk("R10 full cleared, late overrun kept", {14'd0, st_full, st_ovr}, 16'h1);
        clear_all();
        chk("R10 overrun cleared by second sequence", {15'd0, st_ovr}, 16'h0);

        // R11 false start: 4 low clocks only
        for (int c = 0; c < 4; c++) begin @(negedge clk); rx_in = 1'b0; end
        @(negedge clk); rx_in = 1'b1;
        wait_clks(60);
        chk("R11 false start gives nothing", {14'd0, st_full, irq_err}, 16'h0);

        // R9 idle detection
        do_reset();
        ie_full = 0; ie_idle = 1; ie_ovr = 0; ie_noise = 0; ie_frame = 0; ie_par = 0;
        cfg_nine = 0; cfg_par_en = 0;
        wait_clks(300);
        chk("R9 no idle before first character", {15'd0, st_idle}, 16'h0);
        send_frame(9'h05A, 0, 0, 0, 1, 0, 31);
        wait_clks(140);
        chk("R9 8-bit idle not yet at 140", {15'd0, st_idle}, 16'h0);
        wait_clks(35);
        chk("R9 8-bit idle set + irq_rx", {14'd0, st_idle, irq_rx}, 16'h3);
        clear_all();
        wait_clks(300);
        chk("R9 idle only once per period", {15'd0, st_idle}, 16'h0);
        cfg_nine = 1;
        wait_clks(4);
        send_frame(9'h15A, 1, 0, 0, 1, 0, 31);
        wait_clks(160);
        chk("R9 9-bit idle not yet at 160", {15'd0, st_idle}, 16'h0);
        wait_clks(30);
        chk("R9 9-bit idle set", {15'd0, st_idle}, 16'h1);
        chk("R2 9-bit data after idle", {7'd0, rx_data}, 16'h15A);

        finish_run();
    end

endmodule